// File: doc/BRIEF.md
# Digital Video Input Window Timing

This block sits on an 8-bit interleaved 4:2:2 video byte stream that arrives at the system clock rate (27 MHz in the target system). It keeps a horizontal position counter for the byte being received. The counter can be referenced in two ways. One is the rising edge of an external horizontal sync input, which may sit at any phase of the line. The other is an embedded start-of-active-video code that is detected in the stream itself.

From that position the block derives an active-video window flag with a programmable begin and end. It labels each byte inside the window as Cb, Y or Cr, counting from the programmed window begin. It also produces a half-rate pixel clock enable (13.5 MHz at a 27 MHz system clock) whose phase follows the window begin. The input bytes, the position and all flags leave the block together after the same fixed number of register stages. A downstream scaler or capture stage can therefore use them without realignment.

Top module: `vid_win_timing`

## Requirements
- R1: While `rst_n` is low, `dout`, `win_act`, `comp_tag`, `pix_ce` and `hpos` are all zero.
- R2: `dout` equals the byte presented on `din` `OUT_DLY` clock edges earlier. `hpos`, `win_act`, `comp_tag` and `pix_ce` describe that same byte, so every output shares this one latency.
- R3: The position of each byte is one more than the position of the byte before it, and it wraps to 0 after `cfg_line_len`-1. A `cfg_line_len` of 0 selects the parameter `LINE_LEN_DEF` (1716 by default).
- R4: With `cfg_sync_src`=0, the byte that follows a byte sampled with `ext_hsync` high (where the byte before it had `ext_hsync` low) takes position 0. Embedded codes in the stream then have no effect on the position.
- R5: With `cfg_sync_src`=1, a run of 0xFF, 0x00, 0x00, XY in which XY bit 4 is 0 makes the byte after XY take position 0. `ext_hsync` then has no effect on the position.
- R6: An XY with bit 4 set (end of active video) does not reset the position, and neither does a run in which any of the three leading bytes differs from 0xFF, 0x00, 0x00.
- R7: `win_act` is 1 exactly for bytes whose position p satisfies `cfg_win_begin` <= p < `cfg_win_end`.
- R8: When `cfg_win_begin` >= `cfg_win_end`, `win_act` stays 0 for the whole line.
- R9: `comp_tag` is 0 outside the window. Inside it, the tag is set by (p - `cfg_win_begin`) mod 4: 0 gives 1 (Cb), 1 and 3 give 2 (Y), 2 gives 3 (Cr).
- R10: `pix_ce` is 1 when (p - `cfg_win_begin`) is even, on every byte. It is therefore 1 on the first byte of the window and toggles on each following byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one byte per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync_src | input | 1 | Position reference: 0 external sync, 1 embedded code |
| cfg_line_len | input | POS_W | Line length in clocks, 0 selects LINE_LEN_DEF |
| cfg_win_begin | input | POS_W | First position inside the window |
| cfg_win_end | input | POS_W | First position after the window |
| ext_hsync | input | 1 | External horizontal sync, active high |
| din | input | DATA_W | Incoming byte stream |
| dout | output | DATA_W | Delayed copy of `din` |
| win_act | output | 1 | Active-video window flag |
| comp_tag | output | 2 | Component label: 0 none, 1 Cb, 2 Y, 3 Cr |
| pix_ce | output | 1 | Half-rate pixel clock enable |
| hpos | output | POS_W | Position of the byte on `dout` |

## Verification
The bench builds the block with `OUT_DLY`=3 rather than the minimum of 2. This adds a delay stage to the output line, so a wrong stage count shows up as a data and flag mismatch. It sets `LINE_LEN_DEF` to 60, so the default-length wrap selected by a zero `cfg_line_len` occurs within a few dozen bytes. The 11-bit `POS_W` is kept, and short programmed line lengths give many wraps and re-references per run. Odd and even window begins, an empty window and a reversed window are each run after a fresh reset.

// File: rtl/vwt_pkg.sv
package vwt_pkg;

  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_CB   = 2'd1,
    TAG_Y    = 2'd2,
    TAG_CR   = 2'd3
  } comp_tag_e;

  // window membership: begin inclusive, end exclusive, empty when begin >= end
  function automatic logic f_in_window(logic [15:0] pos, logic [15:0] wb, logic [15:0] we);
    return (wb < we) && (pos >= wb) && (pos < we);
  endfunction

  // component label from the offset to the window begin
  function automatic comp_tag_e f_tag(logic [15:0] pos, logic [15:0] wb, logic inwin);
    logic [15:0] off;
    off = pos - wb;
    if (!inwin) return TAG_NONE;
    case (off[1:0])
      2'd0:    return TAG_CB;
      2'd2:    return TAG_CR;
      default: return TAG_Y;
    endcase
  endfunction

  // half-rate enable, phase fixed by the window begin
  function automatic logic f_pix_ce(logic [15:0] pos, logic [15:0] wb);
    logic [15:0] off;
    off = pos - wb;
    return ~off[0];
  endfunction

endpackage

// File: rtl/vwt_sav_detect.sv
module vwt_sav_detect #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic              sav_hit
);
  localparam logic [DATA_W-1:0] CODE_ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] CODE_ZEROS = '0;
  localparam int H_BIT = DATA_W - 4;

  logic [DATA_W-1:0] hist0, hist1, hist2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist0 <= '0;
      hist1 <= '0;
      hist2 <= '0;
    end else begin
      hist0 <= din;
      hist1 <= hist0;
      hist2 <= hist1;
    end
  end

  assign sav_hit = (hist2 == CODE_ONES) && (hist1 == CODE_ZEROS) &&
                   (hist0 == CODE_ZEROS) && !din[H_BIT];
endmodule

// File: rtl/vwt_hcount.sv
module vwt_hcount #(
  parameter int POS_W        = 11,
  parameter int LINE_LEN_DEF = 1716
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_src,
  input  logic             ext_hsync,
  input  logic             sav_hit,
  input  logic [POS_W-1:0] line_len,
  output logic [POS_W-1:0] hcnt,
  output logic             ref_event
);
  localparam logic [POS_W-1:0] DEF_LEN = POS_W'(LINE_LEN_DEF);

  logic             hs_q;
  logic             ext_rise;
  logic [POS_W-1:0] len_sel;
  logic [POS_W-1:0] pos_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hs_q <= 1'b0;
    else        hs_q <= ext_hsync;
  end

  assign ext_rise  = ext_hsync & ~hs_q;
  assign ref_event = sync_src ? sav_hit : ext_rise;
  assign len_sel   = (line_len == '0) ? DEF_LEN : line_len;
  assign pos_last  = len_sel - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hcnt <= '0;
    else if (ref_event)        hcnt <= '0;
    else if (hcnt == pos_last) hcnt <= '0;
    else                       hcnt <= hcnt + 1'b1;
  end
endmodule

// File: rtl/vwt_window.sv
module vwt_window
  import vwt_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] win_begin,
  input  logic [POS_W-1:0] win_end,
  output logic             win,
  output logic [1:0]       tag,
  output logic             pce
);
  logic [15:0] pos16, wb16, we16;
  comp_tag_e   tag_e;

  assign pos16 = 16'(pos);
  assign wb16  = 16'(win_begin);
  assign we16  = 16'(win_end);
  assign win   = f_in_window(pos16, wb16, we16);
  assign tag_e = f_tag(pos16, wb16, win);
  assign tag   = tag_e;
  assign pce   = f_pix_ce(pos16, wb16);
endmodule

// File: rtl/vwt_pipe.sv
module vwt_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] q;
    logic [W-1:0] d;
    if (i == 0) begin : g_first
      assign d = d_in;
    end else begin : g_next
      assign d = g_stage[i-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end
  assign d_out = g_stage[DEPTH-1].q;
endmodule

// File: rtl/vid_win_timing.sv
module vid_win_timing #(
  parameter int DATA_W       = 8,
  parameter int POS_W        = 11,
  parameter int LINE_LEN_DEF = 1716,
  parameter int OUT_DLY      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sync_src,
  input  logic [POS_W-1:0]  cfg_line_len,
  input  logic [POS_W-1:0]  cfg_win_begin,
  input  logic [POS_W-1:0]  cfg_win_end,
  input  logic              ext_hsync,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              win_act,
  output logic [1:0]        comp_tag,
  output logic              pix_ce,
  output logic [POS_W-1:0]  hpos
);
  localparam int PIPE_DEPTH = (OUT_DLY < 2) ? 1 : OUT_DLY - 1;
  localparam int BUNDLE_W   = POS_W + DATA_W + 1 + 2 + 1;

  // named internal events
  logic              sav_hit;
  logic              ref_event;
  logic [POS_W-1:0]  hcnt;

  // first stage: byte and its position
  logic [DATA_W-1:0] st1_data;
  logic [POS_W-1:0]  st1_pos;

  logic              win_c;
  logic [1:0]        tag_c;
  logic              pce_c;
  logic [BUNDLE_W-1:0] bundle_in, bundle_out;

  vwt_sav_detect #(.DATA_W(DATA_W)) u_sav (
    .clk(clk), .rst_n(rst_n), .din(din), .sav_hit(sav_hit)
  );

  vwt_hcount #(.POS_W(POS_W), .LINE_LEN_DEF(LINE_LEN_DEF)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sync_src(cfg_sync_src), .ext_hsync(ext_hsync),
    .sav_hit(sav_hit), .line_len(cfg_line_len), .hcnt(hcnt), .ref_event(ref_event)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_data <= '0;
      st1_pos  <= '0;
    end else begin
      st1_data <= din;
      st1_pos  <= hcnt;
    end
  end

  vwt_window #(.POS_W(POS_W)) u_win (
    .pos(st1_pos), .win_begin(cfg_win_begin), .win_end(cfg_win_end),
    .win(win_c), .tag(tag_c), .pce(pce_c)
  );

  assign bundle_in = {st1_pos, st1_data, win_c, tag_c, pce_c};

  vwt_pipe #(.W(BUNDLE_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .d_in(bundle_in), .d_out(bundle_out)
  );

  assign {hpos, dout, win_act, comp_tag, pix_ce} = bundle_out;
endmodule

// File: rtl/vwt_checker.sv
module vwt_checker #(
  parameter int POS_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_sync_src,
  input logic             ext_hsync,
  input logic             sav_hit,
  input logic [POS_W-1:0] hcnt,
  input logic             win_act,
  input logic [1:0]       comp_tag,
  input logic             pix_ce,
  input logic [POS_W-1:0] hpos
);
  assert_hpos_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != '0) |-> (hpos == $past(hpos) + 1'b1));

  assert_ext_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sync_src && ext_hsync && !$past(ext_hsync)) |=> (hcnt == '0));

  assert_sav_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync_src && sav_hit) |=> (hcnt == '0));

  assert_tag_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_act == (comp_tag != 2'd0));

  assert_window_starts_cb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_act) |-> (comp_tag == 2'd1));

  assert_pce_at_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_act) |-> pix_ce);
endmodule

bind vid_win_timing vwt_checker #(.POS_W(POS_W)) i_vwt_checker (
  .clk(clk), .rst_n(rst_n), .cfg_sync_src(cfg_sync_src), .ext_hsync(ext_hsync),
  .sav_hit(sav_hit), .hcnt(hcnt), .win_act(win_act), .comp_tag(comp_tag),
  .pix_ce(pix_ce), .hpos(hpos)
);

// File: tb/test_vid_win_timing.sv
`timescale 1ns/1ps
module test_vid_win_timing;
  localparam int DATA_W   = 8;
  localparam int POS_W    = 11;
  localparam int DEF_LEN  = 60;
  localparam int OUT_DLY  = 3;
  localparam int POS_MASK = (1 << POS_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_sync_src = 1'b0;
  logic [POS_W-1:0]  cfg_line_len = '0;
  logic [POS_W-1:0]  cfg_win_begin = '0;
  logic [POS_W-1:0]  cfg_win_end = '0;
  logic              ext_hsync = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              win_act;
  logic [1:0]        comp_tag;
  logic              pix_ce;
  logic [POS_W-1:0]  hpos;

  vid_win_timing #(.DATA_W(DATA_W), .POS_W(POS_W), .LINE_LEN_DEF(DEF_LEN), .OUT_DLY(OUT_DLY))
  i_vid_win_timing (
    .clk(clk), .rst_n(rst_n), .cfg_sync_src(cfg_sync_src), .cfg_line_len(cfg_line_len),
    .cfg_win_begin(cfg_win_begin), .cfg_win_end(cfg_win_end), .ext_hsync(ext_hsync),
    .din(din), .dout(dout), .win_act(win_act), .comp_tag(comp_tag), .pix_ce(pix_ce),
    .hpos(hpos)
  );

  always #5 clk = ~clk;

  typedef struct {
    int due;
    int data;
    int win;
    int tag;
    int pce;
    int pos;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;
  string pos_req = "R3";
  string win_req = "R7";

  // reference model state
  int m_cnt, m_h0, m_h1, m_h2, m_hs;

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(string req, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_h0 = 0; m_h1 = 0; m_h2 = 0; m_hs = 0;
  endtask

  // drive one byte and push its expected output (R2..R10)
  task automatic drive_byte(int b, int hs);
    exp_t e;
    int   wb, we, off, last, hit;
    @(negedge clk);
    rst_n = 1'b1;
    din = DATA_W'(b);
    ext_hsync = hs[0];
    wb = int'(cfg_win_begin);
    we = int'(cfg_win_end);
    e.due  = cyc + OUT_DLY;
    e.data = b & 8'hFF;
    e.pos  = m_cnt;
    e.win  = (wb < we && m_cnt >= wb && m_cnt < we) ? 1 : 0;
    off    = (((m_cnt - wb) % 4) + 4) % 4;
    e.pce  = (off % 2 == 0) ? 1 : 0;
    if (e.win == 0)    e.tag = 0;
    else if (off == 0) e.tag = 1;
    else if (off == 2) e.tag = 3;
    else               e.tag = 2;
    exp_q.push_back(e);
    if (cfg_sync_src)
      hit = (m_h2 == 8'hFF && m_h1 == 0 && m_h0 == 0 && ((b >> 4) & 1) == 0) ? 1 : 0;
    else
      hit = (hs != 0 && m_hs == 0) ? 1 : 0;
    last = ((cfg_line_len == 0) ? DEF_LEN : int'(cfg_line_len)) - 1;
    if (hit != 0)          m_cnt = 0;
    else if (m_cnt == last) m_cnt = 0;
    else                   m_cnt = (m_cnt + 1) & POS_MASK;
    m_h2 = m_h1; m_h1 = m_h0; m_h0 = b & 8'hFF; m_hs = hs;
  endtask

  task automatic drain();
    repeat (OUT_DLY + 3) @(negedge clk);
  endtask

  task automatic do_reset(int src, int len, int wb, int we);
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    din = '0;
    ext_hsync = 1'b0;
    cfg_sync_src = src[0];
    cfg_line_len = POS_W'(len);
    cfg_win_begin = POS_W'(wb);
    cfg_win_end = POS_W'(we);
    model_reset();
    repeat (2) @(negedge clk);
    #1;
    check("R1", "dout in reset", int'(dout), 0);
    check("R1", "win_act in reset", int'(win_act), 0);
    check("R1", "comp_tag in reset", int'(comp_tag), 0);
    check("R1", "pix_ce in reset", int'(pix_ce), 0);
    check("R1", "hpos in reset", int'(hpos), 0);
  endtask

  task automatic push_code(int xy, int hs);
    drive_byte(8'hFF, hs);
    drive_byte(8'h00, hs);
    drive_byte(8'h00, hs);
    drive_byte(xy, hs);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      check("R2", "dout", int'(dout), e.data);
      check(pos_req, "hpos", int'(hpos), e.pos);
      check(win_req, "win_act", int'(win_act), e.win);
      check("R9", "comp_tag", int'(comp_tag), e.tag);
      check("R10", "pix_ce", int'(pix_ce), e.pce);
    end
  end

  initial begin
    // phase A: external sync, embedded codes present but ignored (R4, R7)
    pos_req = "R3,R4";
    win_req = "R7";
    do_reset(0, 40, 8, 24);
    for (int i = 0; i < 200; i++) begin
      int hs;
      int b;
      hs = (i == 5 || i == 6 || i == 90 || i == 143 || i == 144 || i == 145) ? 1 : 0;
      b = (i * 37 + 11) & 8'hFF;
      if (i == 50) b = 8'hFF;
      if (i == 51 || i == 52) b = 8'h00;
      if (i == 53) b = 8'h80;
      drive_byte(b, hs);
    end

    // phase B: embedded codes, default line length, ext_hsync ignored (R5, R6)
    drain();
    pos_req = "R3,R5,R6";
    do_reset(1, 0, 4, 20);
    for (int i = 0; i < 10; i++) drive_byte((i % 2 == 0) ? 8'h80 : 8'h10, i % 2);
    push_code(8'h80, 0);
    for (int i = 0; i < 30; i++) drive_byte((i * 13 + 5) & 8'hFF, (i / 7) % 2);
    push_code(8'h9D, 1);
    for (int i = 0; i < 8; i++) drive_byte((i % 2 == 0) ? 8'h80 : 8'h10, (i / 3) % 2);
    drive_byte(8'hFF, 0);
    drive_byte(8'h00, 1);
    drive_byte(8'h01, 0);
    drive_byte(8'h80, 1);
    for (int i = 0; i < 6; i++) drive_byte((i % 2 == 0) ? 8'h80 : 8'h10, 0);
    push_code(8'hAB, 0);
    for (int i = 0; i < 100; i++) drive_byte((i * 29 + 3) & 8'hFF, (i / 7) % 2);

    // phase C: odd window begin (R9, R10)
    drain();
    pos_req = "R3,R4";
    do_reset(0, 30, 5, 13);
    for (int i = 0; i < 100; i++)
      drive_byte((i * 53 + 7) & 8'hFF, (i == 3 || i == 70) ? 1 : 0);

    // phase D and E: empty and reversed windows (R8)
    drain();
    win_req = "R8";
    do_reset(0, 25, 10, 10);
    for (int i = 0; i < 80; i++) drive_byte((i * 17) & 8'hFF, (i == 2) ? 1 : 0);
    drain();
    do_reset(0, 0, 20, 7);
    for (int i = 0; i < 80; i++) drive_byte((i * 71 + 1) & 8'hFF, (i == 9) ? 1 : 0);

    drain();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule